// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of up to four fans (three by default) as a period. Each fan's tach line is synchronised and cleaned of short glitches. The block then counts a slow reference strobe across one full revolution. With two tach pulses per revolution and a 25 kHz strobe, the speed in RPM is 1,500,000 divided by the count. A fan that is stopped, or turning so slowly that the 12-bit counter fills, reads as the all-ones count. A fan reads as all-ones without waiting for a revolution to end.

Software reaches the block through a byte-wide register port. Each fan has a 12-bit measured period and a 12-bit low-speed limit. Each of these is split into an upper and a lower byte. Reading an upper byte also captures the matching lower byte, so the two halves always come from the same value. A per-fan control byte can switch monitoring off. A status byte collects the per-fan alarms, which are also driven on a port.

Top module: `fan_tach_monitor`

## Requirements
- R1: A tach level change is accepted only after it has been stable for FILT_LEN clock cycles (default 3) following a two-flop synchroniser. A one-cycle pulse on the tach line has no effect on the measured count.
- R2: The measured count is the number of ref_tick strobes in one revolution, where a revolution is PULSES_PER_REV (default 2) filtered rising edges of tach. The count becomes visible once a revolution ends. The first edge after reset or after re-enable only starts the measurement.
- R3: The live counter stops at 0xFFF and does not wrap. As soon as it reaches 0xFFF, the reported count becomes 0xFFF, even if no tach edge arrives.
- R4: The count of fan n reads at address 0x20+2n (upper byte, with bits 7:4 reading 0) and at 0x21+2n (lower byte). reg_rdata holds the value one clock after a cycle with reg_rd high.
- R5: A read of an upper-byte address latches the matching lower byte. A later lower-byte read of the same pair returns that latched byte, even if the live value has since changed.
- R6: The low-speed limit of fan n is written and read at 0x28+2n (upper byte, with only bits 3:0 stored) and at 0x29+2n (lower byte). Its reset value is 0xFFF.
- R7: The alarm of fan n is 1 when the count is greater than the limit or equals 0xFFF. A count equal to the limit gives no alarm.
- R8: Bit 7 of the control byte at 0x60+16n disables fan n. While the fan is disabled, its alarm is 0, its live counter is held at zero, and its last reported count is kept. The control byte reads back with bit 7 only.
- R9: The status byte at 0x38 reads fan n's alarm in bit n, and fan_alarm carries the same bits.
- R10: After reset, every count reads 0, every alarm is 0, and every fan is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe of the counted reference (25 kHz) |
| tach_in | input | NUM_FANS | Raw tach lines, one per fan |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after reg_rd |
| fan_alarm | output | NUM_FANS | Per-fan low-speed alarm |

## Verification
A live counter that wraps or loses its saturation shows up as a stopped fan reading a small count instead of 0xFFF. It also shows as a missing alarm, about 4096 strobes after the tach line stops. A revolution-edge counter in the wrong state gives counts that are half or twice the expected value, visible on the first register read after one revolution. A stale or wrongly tagged holding byte returns a lower byte from a different value, visible on the very next lower-byte read. A filter that passes short pulses inserts extra edges and shortens the count within one revolution.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
   localparam logic [7:0] CNT_BASE    = 8'h20;
   localparam logic [7:0] LIM_BASE    = 8'h28;
   localparam logic [7:0] CTRL_BASE   = 8'h60;
   localparam int         CTRL_STRIDE = 16;
   localparam logic [7:0] STAT_ADDR   = 8'h38;
   localparam int         DIS_BIT     = 7;

   function automatic logic [7:0] upper_byte(input logic [15:0] v);
      return v[15:8];
   endfunction

   function automatic logic [7:0] lower_byte(input logic [15:0] v);
      return v[7:0];
   endfunction
endpackage

// File: rtl/tach_conditioner.sv
module tach_conditioner #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tach_raw,
   output logic rise
);
   localparam int FW = $clog2(FILT_LEN + 1);

   logic          sync1_q, sync2_q, level_q;
   logic [FW-1:0] run_q;
   logic          accept;

   assign accept = (sync2_q != level_q) && (run_q == FW'(FILT_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= 1'b0;
         sync2_q <= 1'b0;
         level_q <= 1'b0;
         run_q   <= '0;
         rise    <= 1'b0;
      end else begin
         sync1_q <= tach_raw;
         sync2_q <= sync1_q;
         rise    <= accept && sync2_q;
         if (accept) begin
            level_q <= sync2_q;
            run_q   <= '0;
         end else if (sync2_q != level_q) begin
            run_q   <= run_q + 1'b1;
         end else begin
            run_q   <= '0;
         end
      end
   end

   // R1
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_q) |-> ($past(sync2_q) == level_q));
endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
   parameter int CNT_W = 12,
   parameter int PPR   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             rev_edge,
   output logic [CNT_W-1:0] period
);
   localparam logic [CNT_W-1:0] SAT = '1;
   localparam int PW = (PPR > 1) ? $clog2(PPR) : 1;

   logic [CNT_W-1:0] live_q;
   logic [PW-1:0]    pcnt_q;
   logic             armed_q;
   logic             rev_done;
   logic [CNT_W-1:0] bumped, fresh;

   assign rev_done = enable && armed_q && rev_edge && (pcnt_q == PW'(PPR - 1));
   assign bumped   = (tick && live_q != SAT) ? live_q + 1'b1 : live_q;
   assign fresh    = tick ? CNT_W'(1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= '0;
         pcnt_q  <= '0;
         armed_q <= 1'b0;
         period  <= '0;
      end else if (!enable) begin
         live_q  <= '0;
         pcnt_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (live_q == SAT) period <= SAT;
         if (rev_edge && !armed_q) begin
            armed_q <= 1'b1;
            pcnt_q  <= '0;
            live_q  <= fresh;
         end else if (rev_done) begin
            pcnt_q  <= '0;
            period  <= live_q;
            live_q  <= fresh;
         end else begin
            if (rev_edge) pcnt_q <= pcnt_q + 1'b1;
            live_q <= bumped;
         end
      end
   end

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && live_q == SAT && !rev_edge) |=> (live_q == SAT));
   // R3
   sat_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && live_q == SAT) |=> (period == SAT));
   // R2
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rev_done |=> (period == $past(live_q)));
   // R8
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (live_q == '0 && $stable(period)));
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
   import fan_tach_pkg::*;
#(
   parameter int NUM_FANS       = 3,
   parameter int CNT_W          = 12,
   parameter int PULSES_PER_REV = 2,
   parameter int FILT_LEN       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_tick,
   input  logic [NUM_FANS-1:0] tach_in,
   input  logic [7:0]          reg_addr,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   output logic [NUM_FANS-1:0] fan_alarm
);
   localparam logic [CNT_W-1:0] SAT  = '1;
   localparam int               HI_W = CNT_W - 8;

   if (NUM_FANS < 1 || NUM_FANS > 4) begin : g_bad_fans
      $error("NUM_FANS must be 1 to 4");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("CNT_W must be 9 to 16");
   end
   if (PULSES_PER_REV < 1 || FILT_LEN < 1) begin : g_bad_opts
      $error("PULSES_PER_REV and FILT_LEN must be positive");
   end

   logic [CNT_W-1:0]    period_w [NUM_FANS];
   logic [CNT_W-1:0]    limit_q  [NUM_FANS];
   logic [NUM_FANS-1:0] dis_q;
   logic [NUM_FANS-1:0] rise_w;

   for (genvar n = 0; n < NUM_FANS; n++) begin : g_fan
      localparam logic [7:0] A_LIM_HI = LIM_BASE + 8'(2 * n);
      localparam logic [7:0] A_LIM_LO = LIM_BASE + 8'(2 * n + 1);
      localparam logic [7:0] A_CTRL   = CTRL_BASE + 8'(CTRL_STRIDE * n);

      tach_conditioner #(.FILT_LEN(FILT_LEN)) i_cond (
         .clk      (clk),
         .rst_n    (rst_n),
         .tach_raw (tach_in[n]),
         .rise     (rise_w[n])
      );

      tach_period_counter #(.CNT_W(CNT_W), .PPR(PULSES_PER_REV)) i_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .enable   (!dis_q[n]),
         .tick     (ref_tick),
         .rev_edge (rise_w[n]),
         .period   (period_w[n])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            limit_q[n] <= SAT;
            dis_q[n]   <= 1'b0;
         end else if (reg_wr) begin
            if (reg_addr == A_LIM_HI) limit_q[n][CNT_W-1:8] <= reg_wdata[HI_W-1:0];
            if (reg_addr == A_LIM_LO) limit_q[n][7:0]       <= reg_wdata;
            if (reg_addr == A_CTRL)   dis_q[n]              <= reg_wdata[DIS_BIT];
         end
      end

      assign fan_alarm[n] = !dis_q[n] && ((period_w[n] > limit_q[n]) || (period_w[n] == SAT));

      // R8
      quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dis_q[n] |-> !fan_alarm[n]);
      // R7
      slow_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!dis_q[n] && period_w[n] == SAT) |-> fan_alarm[n]);
   end

   logic [7:0] hold_q;
   logic [6:0] hold_tag_q;
   logic       hold_ok_q;
   logic [7:0] rd_val, latch_val;
   logic       latch_hit, cnt_hi_sel;
   logic [7:0] stat_byte;

   always_comb begin
      stat_byte = '0;
      stat_byte[NUM_FANS-1:0] = fan_alarm;
   end

   always_comb begin
      rd_val     = '0;
      latch_val  = '0;
      latch_hit  = 1'b0;
      cnt_hi_sel = 1'b0;
      for (int n = 0; n < NUM_FANS; n++) begin
         if (reg_addr == CNT_BASE + 8'(2 * n)) begin
            rd_val     = upper_byte(16'(period_w[n]));
            latch_val  = lower_byte(16'(period_w[n]));
            latch_hit  = 1'b1;
            cnt_hi_sel = 1'b1;
         end
         if (reg_addr == CNT_BASE + 8'(2 * n + 1))
            rd_val = (hold_ok_q && hold_tag_q == reg_addr[7:1]) ? hold_q
                                                                : lower_byte(16'(period_w[n]));
         if (reg_addr == LIM_BASE + 8'(2 * n)) begin
            rd_val    = upper_byte(16'(limit_q[n]));
            latch_val = lower_byte(16'(limit_q[n]));
            latch_hit = 1'b1;
         end
         if (reg_addr == LIM_BASE + 8'(2 * n + 1))
            rd_val = (hold_ok_q && hold_tag_q == reg_addr[7:1]) ? hold_q
                                                                : lower_byte(16'(limit_q[n]));
         if (reg_addr == CTRL_BASE + 8'(CTRL_STRIDE * n))
            rd_val = {dis_q[n], 7'b0};
      end
      if (reg_addr == STAT_ADDR) rd_val = stat_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         hold_q     <= '0;
         hold_tag_q <= '0;
         hold_ok_q  <= 1'b0;
      end else if (reg_rd) begin
         reg_rdata <= rd_val;
         if (latch_hit) begin
            hold_q     <= latch_val;
            hold_tag_q <= reg_addr[7:1];
            hold_ok_q  <= 1'b1;
         end
      end
   end

   // R9
   status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == STAT_ADDR) |=> (reg_rdata[NUM_FANS-1:0] == $past(fan_alarm)));
   // R4
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && cnt_hi_sel) |=> ((reg_rdata >> HI_W) == 8'd0));
endmodule

// File: tb/test_fan_tach_monitor.sv
module test_fan_tach_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int NF         = 3;
   localparam int TICK_DIV   = 4;
   localparam int NV         = 7;

   // fan, tach half period (clk), limit, expected count, expected alarm
   localparam int V_FAN  [NV] = '{0, 1, 2, 0, 1, 2, 0};
   localparam int V_HALF [NV] = '{20, 30, 25, 60, 50, 200, 300};
   localparam int V_LIM  [NV] = '{4095, 30, 24, 59, 100, 10, 256};
   localparam int V_CNT  [NV] = '{20, 30, 25, 60, 50, 200, 300};
   localparam int V_ALM  [NV] = '{0, 0, 1, 1, 0, 1, 1};

   logic          clk = 0;
   logic          rst_n = 0;
   logic          ref_tick = 0;
   logic [NF-1:0] tach_in;
   logic [7:0]    reg_addr = 0;
   logic          reg_wr = 0, reg_rd = 0;
   logic [7:0]    reg_wdata = 0;
   logic [7:0]    reg_rdata;
   logic [NF-1:0] fan_alarm;

   int total = 0, bad = 0;
   int half [NF] = '{0, 0, 0};
   logic [NF-1:0] glitch_en = '0;
   int tcnt [NF];
   logic [NF-1:0] tgen, gpulse;
   int tdiv = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fan_tach_monitor i_fan_tach_monitor (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fan_alarm(fan_alarm)
   );

   always @(posedge clk) begin
      tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      ref_tick <= (tdiv == TICK_DIV - 1);
      for (int n = 0; n < NF; n++) begin
         if (half[n] == 0) begin
            tcnt[n] <= 0; tgen[n] <= 1'b0; gpulse[n] <= 1'b0;
         end else begin
            gpulse[n] <= glitch_en[n] && !tgen[n] && (tcnt[n] == half[n] / 2);
            if (tcnt[n] >= half[n] - 1) begin
               tcnt[n] <= 0; tgen[n] <= ~tgen[n];
            end else tcnt[n] <= tcnt[n] + 1;
         end
      end
   end
   assign tach_in = tgen | gpulse;

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1;
      @(negedge clk); reg_rd = 0; d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd16(input logic [7:0] a, output int v);
      logic [7:0] h, l;
      rd(a, h); rd(a + 8'd1, l);
      v = {h, l};
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      logic [7:0] b;
      tgen = '0; gpulse = '0;
      for (int n = 0; n < NF; n++) tcnt[n] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      rd16(8'h20, v);  chk("R10 count after reset", v, 0);
      rd16(8'h2A, v);  chk("R6 limit reset", v, 12'hFFF);
      rd(8'h38, b);    chk("R10 status after reset", b, 0);
      chk("R10 alarm port after reset", fan_alarm, 0);
      rd(8'h60, b);    chk("R10 control after reset", b, 0);

      half[0] = 20; half[1] = 30; half[2] = 25;

      // R2 R7 table walk
      for (int i = 0; i < NV; i++) begin
         int f;
         f = V_FAN[i];
         wr(8'h28 + 8'(2 * f), 8'(V_LIM[i] >> 8));
         wr(8'h29 + 8'(2 * f), 8'(V_LIM[i]));
         half[f] = V_HALF[i];
         repeat (12 * V_HALF[i] + 1300) @(posedge clk);
         @(negedge clk);
         rd16(8'h20 + 8'(2 * f), v);  chk("R2 period count", v, V_CNT[i]);
         rd16(8'h28 + 8'(2 * f), v);  chk("R6 limit readback", v, V_LIM[i]);
         chk("R7 alarm port", fan_alarm[f], V_ALM[i]);
         rd(8'h38, b);                chk("R9 status bit", b[f], V_ALM[i]);
      end

      // R1 glitch rejection
      half[0] = 40; glitch_en[0] = 1;
      repeat (2000) @(posedge clk);
      rd16(8'h20, v); chk("R1 glitch ignored", v, 40);
      glitch_en[0] = 0;

      // R5 byte-pair coherence
      rd(8'h20, b); chk("R5 upper byte", b, 0);
      half[0] = 20;
      repeat (1500) @(posedge clk);
      rd(8'h21, b); chk("R5 latched lower byte", b, 8'h28);
      rd16(8'h20, v); chk("R5 fresh pair", v, 20);

      // R6 unused limit bits
      wr(8'h2A, 8'hFF);
      rd(8'h2A, b); chk("R6 limit upper nibble", b, 8'h0F);
      wr(8'h2B, 8'hFF);

      // R3 saturation, R8 disable
      wr(8'h80, 8'h80);
      rd(8'h80, b); chk("R8 control readback", b, 8'h80);
      half[1] = 0; half[2] = 0;
      wr(8'h2A, 8'h0F); wr(8'h2B, 8'hFF);
      repeat (17000) @(posedge clk);
      @(negedge clk);
      rd16(8'h22, v); chk("R3 saturated count", v, 12'hFFF);
      chk("R3 saturated alarm", fan_alarm[1], 1);
      chk("R8 disabled no alarm", fan_alarm[2], 0);
      rd16(8'h24, v); chk("R8 count kept while disabled", v, 200);
      rd(8'h38, b); chk("R9 status pattern", b, 8'h02);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule